// File: doc/BRIEF.md
# UART RTS Line and Half-Duplex Direction Controller

This block decides the level of a UART's RTS output and tells the transmitter whether it may start a new character. RTS has three possible sources, in priority order. The first is a half-duplex direction mode that follows transmit activity, so that RTS can enable an external line driver. The second is a receive-side flow controller with hysteresis, driven by the receive-FIFO fill level. The third is a manual bit written by software.

The transmit permit depends only on the CTS pin, and only when CTS gating is enabled. The transmitter samples the permit at the start of each character. A character that is already being shifted out is never cut short. The block holds one registered RTS level and two small state bits. It has no FIFO, no baud logic and no register interface of its own.

Top module: `uart_rts_ctl`

## Requirements
- R1: During reset and on every cycle after it until a configuration input changes, `rts_pin` is 1. With `cfg_cts_gate` at 0, `tx_permit` is 1.
- R2: When `cfg_dir_auto` and `cfg_rts_flow` are both 0, `rts_pin` takes the value `!cfg_rts_manual` on the next clock edge. A manual bit of 1 therefore drives the pin low.
- R3: When `cfg_rts_flow` is 1 and `cfg_dir_auto` is 0, flow control works as follows. The halt level is 4 × `rx_thresholds[3:0]` and the resume level is 4 × `rx_thresholds[7:4]`. At a clock edge where `rx_fill` ≥ halt level, RTS goes to 1. At an edge where `rx_fill` ≤ resume level, it goes to 0. Between the two levels it keeps its state. Disabling flow control clears the state.
- R4: If the resume level is not below the halt level, the flow state keeps its current value whatever the fill is.
- R5: While `cfg_dir_auto` is 1, neither `cfg_rts_manual` nor the flow controller affects `rts_pin`.
- R6: In direction mode with `cfg_dir_invert` at 0, a clock edge that samples `txq_write` high drives `rts_pin` to 0. `rts_pin` returns to 1 at the first later edge that samples `tx_fifo_empty` at 1, `tx_shift_busy` at 0 and no write. The direction state is cleared while the mode is off.
- R7: With `cfg_dir_invert` at 1 in direction mode, the R6 levels are swapped: 1 while data is pending and 0 once idle. Outside direction mode the invert bit has no effect.
- R8: `tx_permit` is 0 exactly when `cfg_cts_gate` is 1 and `cts_pin` is 1, independent of `tx_shift_busy`.
- R9: `rts_pin` is a register output and changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rts_manual | input | 1 | Manual RTS request (1 drives the pin low) |
| cfg_rts_flow | input | 1 | Enable receive-threshold RTS control |
| cfg_cts_gate | input | 1 | Enable CTS gating of transmit start |
| cfg_dir_auto | input | 1 | Enable half-duplex direction mode |
| cfg_dir_invert | input | 1 | Invert RTS in direction mode |
| rx_thresholds | input | 8 | [3:0] halt level / 4, [7:4] resume level / 4 |
| rx_fill | input | 7 | Receive-FIFO fill, 0 to 64 |
| txq_write | input | 1 | One-cycle pulse per host write to the transmit FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_busy | input | 1 | Shift register is sending a character |
| cts_pin | input | 1 | CTS pin level (already synchronised) |
| rts_pin | output | 1 | RTS pin level |
| tx_permit | output | 1 | Transmitter may begin a new character |

## Verification
The fill level is swept up and down across both thresholds, and fills equal to each threshold are included. A controller that lacks hysteresis, or that compares with the wrong inequality, would toggle RTS one step early or would chatter between the levels. Direction mode is checked with a write that arrives while the FIFO still reads empty, and with the shifter busy after the FIFO drains. A design that releases on FIFO-empty alone would drop the driver in the middle of a character. A design that lets the release beat a simultaneous write would lose the turn-on. Inverted and degenerate threshold settings, and mode changes in the middle of a transfer, are mixed in by a long random run. That run is compared against the reference on every cycle.

// File: rtl/uart_rts_ctl.sv
module uart_rts_ctl #(
  parameter int FILL_W   = 7,
  parameter int THR_W    = 4,
  parameter int SCALE_SH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_rts_manual,
  input  logic                 cfg_rts_flow,
  input  logic                 cfg_cts_gate,
  input  logic                 cfg_dir_auto,
  input  logic                 cfg_dir_invert,
  input  logic [2*THR_W-1:0]   rx_thresholds,
  input  logic [FILL_W-1:0]    rx_fill,
  input  logic                 txq_write,
  input  logic                 tx_fifo_empty,
  input  logic                 tx_shift_busy,
  input  logic                 cts_pin,
  output logic                 rts_pin,
  output logic                 tx_permit
);
  localparam int LVL_W = THR_W + SCALE_SH;
  localparam int PAD_W = FILL_W - LVL_W;

  logic [FILL_W-1:0] halt_lvl, resume_lvl;
  logic flow_halt, flow_next;
  logic dir_busy, dir_next;
  logic rts_next;

  assign halt_lvl   = {{PAD_W{1'b0}}, rx_thresholds[THR_W-1:0], {SCALE_SH{1'b0}}};
  assign resume_lvl = {{PAD_W{1'b0}}, rx_thresholds[2*THR_W-1:THR_W], {SCALE_SH{1'b0}}};

  always_comb begin
    flow_next = flow_halt;
    if (!cfg_rts_flow)
      flow_next = 1'b0;
    else if (resume_lvl < halt_lvl) begin
      if (rx_fill >= halt_lvl)        flow_next = 1'b1;
      else if (rx_fill <= resume_lvl) flow_next = 1'b0;
    end
  end

  always_comb begin
    dir_next = dir_busy;
    if (!cfg_dir_auto)                      dir_next = 1'b0;
    else if (txq_write)                     dir_next = 1'b1;
    else if (tx_fifo_empty && !tx_shift_busy) dir_next = 1'b0;
  end

  always_comb begin
    if (cfg_dir_auto)      rts_next = cfg_dir_invert ? dir_next : !dir_next;
    else if (cfg_rts_flow) rts_next = flow_next;
    else                   rts_next = !cfg_rts_manual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_halt <= 1'b0;
      dir_busy  <= 1'b0;
      rts_pin   <= 1'b1;
    end else begin
      flow_halt <= flow_next;
      dir_busy  <= dir_next;
      rts_pin   <= rts_next;
    end
  end

  assign tx_permit = !(cfg_cts_gate && cts_pin);

  assert_manual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_auto && !cfg_rts_flow && cfg_rts_manual) |=> !rts_pin);

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_auto && cfg_rts_flow && resume_lvl < halt_lvl && rx_fill >= halt_lvl) |=> rts_pin);

  assert_write_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_auto && !cfg_dir_invert && txq_write) |=> !rts_pin);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_auto && !cfg_dir_invert && !txq_write && tx_fifo_empty && !tx_shift_busy) |=> rts_pin);

  assert_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_auto && cfg_dir_invert && txq_write) |=> rts_pin);
endmodule

// File: tb/uart_rts_ctl_test.sv
module uart_rts_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic man = 0, flw = 0, gate = 0, dauto = 0, dinv = 0;
  logic [7:0] thr = 0;
  logic [6:0] fill = 0;
  logic wr = 0, empty = 1, busy = 0, cts = 0;
  logic rts_pin, tx_permit;
  int vectors = 0, errors = 0;
  int m_rts = 1, m_dir = 0, m_flow = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rts_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_rts_manual(man), .cfg_rts_flow(flw),
    .cfg_cts_gate(gate), .cfg_dir_auto(dauto), .cfg_dir_invert(dinv),
    .rx_thresholds(thr), .rx_fill(fill), .txq_write(wr),
    .tx_fifo_empty(empty), .tx_shift_busy(busy), .cts_pin(cts),
    .rts_pin(rts_pin), .tx_permit(tx_permit));

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rts = 1; m_dir = 0; m_flow = 0;
    end else begin
      int h, r;
      h = thr[3:0] * 4; r = thr[7:4] * 4;
      if (!dauto) m_dir = 0;
      else if (wr) m_dir = 1;
      else if (empty && !busy) m_dir = 0;
      if (!flw) m_flow = 0;
      else if (r < h) begin
        if (fill >= h) m_flow = 1;
        else if (fill <= r) m_flow = 0;
      end
      if (dauto) m_rts = dinv ? m_dir : 1 - m_dir;
      else if (flw) m_rts = m_flow;
      else m_rts = man ? 0 : 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rts_req();
    if (dauto) return dinv ? "R7" : "R6/R5";
    if (flw) return "R3/R4";
    return "R2";
  endfunction

  // one cycle: compare RTS, apply new inputs, compare permit
  task automatic step(input logic n_man, n_flw, n_gate, n_auto, n_inv,
                      input logic [7:0] n_thr, input logic [6:0] n_fill,
                      input logic n_wr, n_empty, n_busy, n_cts);
    @(negedge clk);
    check({rts_req(), " R9 rts"}, rts_pin, m_rts);
    man = n_man; flw = n_flw; gate = n_gate; dauto = n_auto; dinv = n_inv;
    thr = n_thr; fill = n_fill; wr = n_wr; empty = n_empty; busy = n_busy; cts = n_cts;
    #1;
    check("R8 permit", tx_permit, (gate && cts) ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    check("R1 rts in reset", rts_pin, 1);
    check("R1 permit in reset", tx_permit, 1);
    rst_n = 1;
    repeat (3) step(0,0,0,0,0, 8'h00, 0, 0,1,0,0);
    // R2 manual
    step(1,0,0,0,0, 8'h00, 0, 0,1,0,0);
    step(1,0,0,0,0, 8'h00, 0, 0,1,0,0);
    step(0,0,0,0,0, 8'h00, 0, 0,1,0,0);
    step(0,0,0,0,0, 8'h00, 0, 0,1,0,0);
    // R7 invert ignored outside direction mode
    step(1,0,0,0,1, 8'h00, 0, 0,1,0,0);
    step(1,0,0,0,1, 8'h00, 0, 0,1,0,0);
    // R3 sweep: halt 32, resume 16
    for (int f = 0; f <= 64; f++) step(0,1,0,0,0, 8'h48, 7'(f), 0,1,0,0);
    for (int f = 64; f >= 0; f--) step(0,1,0,0,0, 8'h48, 7'(f), 0,1,0,0);
    // R4 degenerate thresholds
    for (int f = 0; f <= 64; f += 4) step(0,1,0,0,0, 8'h84, 7'(f), 0,1,0,0);
    step(0,1,0,0,0, 8'h48, 40, 0,1,0,0);
    for (int f = 64; f >= 0; f -= 4) step(0,1,0,0,0, 8'h44, 7'(f), 0,1,0,0);
    // R5/R6 direction mode overriding flow and manual
    step(1,1,0,1,0, 8'h48, 64, 0,1,0,0);
    step(1,1,0,1,0, 8'h48, 64, 1,1,0,0);
    step(1,1,0,1,0, 8'h48, 64, 0,0,1,0);
    step(1,1,0,1,0, 8'h48, 64, 1,0,1,0);
    step(1,1,0,1,0, 8'h48, 64, 0,1,1,0);
    step(1,1,0,1,0, 8'h48, 64, 0,1,1,0);
    step(1,1,0,1,0, 8'h48, 64, 0,1,0,0);
    step(1,1,0,1,0, 8'h48, 64, 0,1,0,0);
    // R7 inverted
    step(0,0,0,1,1, 8'h00, 0, 1,1,0,0);
    step(0,0,0,1,1, 8'h00, 0, 0,1,1,0);
    step(0,0,0,1,1, 8'h00, 0, 0,1,0,0);
    step(0,0,0,1,1, 8'h00, 0, 0,1,0,0);
    // R8 CTS gating with shifter busy
    step(0,0,1,0,0, 8'h00, 0, 0,0,1,1);
    step(0,0,1,0,0, 8'h00, 0, 0,0,1,0);
    step(0,0,0,0,0, 8'h00, 0, 0,0,1,1);
    step(0,0,1,0,0, 8'h00, 0, 0,1,0,1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2], (r[3] | r[4]), r[5], r[15:8], 7'(r[22:16] % 65),
           (r[23] & r[24]), r[25], r[26] & r[27], r[28]);
    end
    step(0,0,0,0,0, 8'h00, 0, 0,1,0,0);
    @(negedge clk);
    check("R2 final", rts_pin, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule